// File: doc/BRIEF.md
# Serial-In Latched Parallel Output Register

This block is the logic core of an eight-channel serial-loaded output driver. Bits arrive one per rising clock edge on a serial input and march along a shift chain. The last stage of the chain is brought out on a serial output, so several blocks can be daisy-chained into a longer register. A strobe input copies the shift chain into a bank of holding latches while it is high and freezes them when it is low. An active-low enable then either passes the held bits to the parallel outputs or forces every output low.

Every storage element sits in the clock domain and is cleared by a synchronous active-high reset. The holding bank samples the value the chain takes on the same edge, so with the strobe high it tracks the chain with no added cycle. The parallel outputs are registered: after an edge they show the gated value of the holding bank as it stands after that edge. The enable never alters the chain or the holding bank; it only selects what leaves the block.

Top module: `srl_driver_core`

## Requirements
- R1: A clock edge with `rst` high clears the shift chain, the holding bank, `pout` and `sout` to zero.
- R2: On each rising edge with `rst` low, stage 0 takes `sin` and every stage k above 0 takes the former value of stage k-1; stage k drives bit k of the chain, so `pout[0]` carries the newest bit.
- R3: `sout` always equals the last stage of the shift chain, so after WIDTH edges a bit entered on `sin` appears on `sout`.
- R4: On an edge with `strobe` high, the holding bank takes the value the shift chain holds after that same edge.
- R5: On an edge with `strobe` low, the holding bank keeps its value.
- R6: After an edge with `oe_n` low, `pout` equals the holding bank; after an edge with `oe_n` high, `pout` is all zeros.
- R7: `oe_n` has no effect on the contents of the shift chain or the holding bank; dropping `oe_n` after a blanked period shows the held bits unchanged.
- R8: Two blocks joined with the first `sout` driving the second `sin` behave as one 2*WIDTH-stage chain, the second block holding the older bits.
- R9: With `strobe` held high and `oe_n` low, `pout` follows the shifting chain on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sin | input | 1 | Serial data input, sampled on the rising edge |
| strobe | input | 1 | High: holding bank follows the chain; low: holds |
| oe_n | input | 1 | Active-low output enable; high forces `pout` to zero |
| pout | output | WIDTH | Registered parallel outputs, bit 0 is the newest bit |
| sout | output | 1 | Last shift stage, for cascading |

## Verification
The assertions check, on every cycle, that the chain advances by one stage and takes `sin`, that a high strobe leaves the holding bank equal to the chain, that a low strobe keeps it stable, that a high enable blanks the outputs and that reset clears the outputs. What only the bench scenarios can show is that the enable leaves stored data untouched across a long blanked period with shifting in progress, that a cascaded pair forms one longer chain with the right bit order, and that a permanently high strobe makes the outputs ripple with the data.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int unsigned SRL_DEFAULT_W = 8;
  typedef enum logic {OUT_DRIVE = 1'b0, OUT_BLANK = 1'b1} oe_mode_e;
endpackage

// File: rtl/srl_shift_chain.sv
module srl_shift_chain #(
  parameter int unsigned W = srl_pkg::SRL_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sin,
  output logic [W-1:0] chain_d,
  output logic [W-1:0] chain_q
);
  localparam int unsigned TOP = W - 1;

  always_comb begin
    chain_d = {chain_q[TOP-1:0], sin};
  end

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= chain_d;
  end

  // R2: each stage takes its lower neighbour, stage 0 takes the serial input
  assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (chain_q[TOP:1] == $past(chain_q[TOP-1:0])) && (chain_q[0] == $past(sin)))
    else $error("assert_shift_R2");
endmodule

// File: rtl/srl_hold_bank.sv
module srl_hold_bank #(
  parameter int unsigned W = srl_pkg::SRL_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] chain_d,
  input  logic [W-1:0] chain_q,
  output logic [W-1:0] lat_d
);
  logic [W-1:0] lat_q;

  always_comb begin
    lat_d = strobe ? chain_d : lat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= lat_d;
  end

  // R4: a high strobe leaves the bank equal to the chain after the edge
  assert_follow_R4: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (lat_q == chain_q));

  // R5: a low strobe keeps the bank unchanged
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(lat_q));
endmodule

// File: rtl/srl_out_gate.sv
module srl_out_gate #(
  parameter int unsigned W = srl_pkg::SRL_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic [W-1:0] lat_d,
  output logic [W-1:0] pout
);
  import srl_pkg::*;

  oe_mode_e mode;
  assign mode = oe_mode_e'(oe_n);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                   pout[i] <= 1'b0;
      else if (mode == OUT_BLANK) pout[i] <= 1'b0;
      else                        pout[i] <= lat_d[i];
    end
  end

  // R6: a high enable blanks every output on the next cycle
  assert_blank_R6: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (pout == '0));
endmodule

// File: rtl/srl_driver_core.sv
module srl_driver_core #(
  parameter int unsigned WIDTH = srl_pkg::SRL_DEFAULT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sin,
  input  logic             strobe,
  input  logic             oe_n,
  output logic [WIDTH-1:0] pout,
  output logic             sout
);
  logic [WIDTH-1:0] chain_d;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] lat_d;

  srl_shift_chain #(.W(WIDTH)) u_chain (
    .clk(clk), .rst(rst), .sin(sin), .chain_d(chain_d), .chain_q(chain_q)
  );

  srl_hold_bank #(.W(WIDTH)) u_hold (
    .clk(clk), .rst(rst), .strobe(strobe),
    .chain_d(chain_d), .chain_q(chain_q), .lat_d(lat_d)
  );

  srl_out_gate #(.W(WIDTH)) u_gate (
    .clk(clk), .rst(rst), .oe_n(oe_n), .lat_d(lat_d), .pout(pout)
  );

  assign sout = chain_q[WIDTH-1];

  // R1: a reset edge leaves outputs and serial output cleared
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pout == '0) && (sout == 1'b0));
endmodule

// File: tb/sim_srl_driver_core.sv
module sim_srl_driver_core;
  localparam int unsigned W = 8;
  localparam int unsigned W2 = 2 * W;

  typedef struct {
    string        tag;
    logic [W2-1:0] pout;
    logic          sout_a;
    logic          sout_b;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sin = 1'b0;
  logic strobe = 1'b0;
  logic oe_n = 1'b1;
  logic [W-1:0] pout_a, pout_b;
  logic sout_a, sout_b;

  always #2.5 clk = ~clk;

  srl_driver_core #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .sin(sin), .strobe(strobe), .oe_n(oe_n),
    .pout(pout_a), .sout(sout_a)
  );
  srl_driver_core #(.WIDTH(W)) u1 (
    .clk(clk), .rst(rst), .sin(sout_a), .strobe(strobe), .oe_n(oe_n),
    .pout(pout_b), .sout(sout_b)
  );

  exp_t q[$];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [W2-1:0] m_chain = '0;
  logic [W2-1:0] m_lat = '0;
  logic [W2-1:0] m_out = '0;

  task automatic step(input logic r, input logic d, input logic st,
                      input logic oen, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; sin = d; strobe = st; oe_n = oen;
    if (r) begin
      m_chain = '0; m_lat = '0; m_out = '0;
    end else begin
      m_chain = {m_chain[W2-2:0], d};
      if (st) m_lat = m_chain;
      m_out = oen ? '0 : m_lat;
    end
    e.tag = tag;
    e.pout = m_out;
    e.sout_a = m_chain[W-1];
    e.sout_b = m_chain[W2-1];
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        tests++;
        if ({pout_b, pout_a} !== e.pout || sout_a !== e.sout_a || sout_b !== e.sout_b) begin
          fails++;
          $display("FAIL %s: pout=%h sout=%b%b expected pout=%h sout=%b%b",
                   e.tag, {pout_b, pout_a}, sout_b, sout_a, e.pout, e.sout_b, e.sout_a);
        end
      end
    end
  end

  initial begin : driver
    logic [W2-1:0] pat;
    pat = 16'hA5C3;
    // R1: reset state
    step(1, 0, 0, 1, "R1");
    step(1, 0, 0, 1, "R1");
    // R9, R2, R3: strobe high, outputs ripple with shifting data
    for (int i = W2 - 1; i >= 0; i--) step(0, pat[i], 1, 0, "R9,R2,R3");
    // R5: strobe low, outputs hold while chain keeps shifting
    for (int i = 0; i < 5; i++) step(0, i[0], 0, 0, "R5,R3");
    // R6: enable high blanks outputs
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, "R6");
    // R7: shift while blanked, then re-enable: held bits unchanged
    for (int i = 0; i < 4; i++) step(0, i[1], 0, 1, "R7");
    step(0, 0, 0, 0, "R7");
    step(0, 1, 0, 0, "R7");
    // R4: strobe pulse copies current chain
    step(0, 1, 1, 0, "R4");
    step(0, 0, 0, 0, "R5");
    // R8: flush the cascade, bits travel through both stages to the far end
    for (int i = 0; i < W2; i++) step(0, 0, 0, 0, "R8,R3");
    step(0, 0, 1, 0, "R4");
    // R1: reset in the middle of activity
    step(0, 1, 1, 0, "R2");
    step(1, 1, 1, 0, "R1");
    step(0, 0, 0, 0, "R1");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule